// File: doc/BRIEF.md
# Scan Test Mode Sequencer

This controller moves a clock-gated logic block between mission operation and scan testing. It accepts single-cycle mode requests from a tester port and derives every test control for the block from one state register. Those controls are the test-mode flag, scan enable, the clock-gate force, the clock-source select, the reset gate and interface isolation. Because all of them come from the same state, the block can never be left half in one mode and half in another. The only legal route is from functional into scan-shift. Shift and capture may then alternate freely, and functional mode can be re-entered only from shift.

When capture is requested, scan enable drops at once. A programmable settle count must then run out, and the block's clock must have moved from the slow shift clock to the fast capture clock, before the sequencer asks the on-chip clock controller for a burst of 1 to 4 at-speed pulses. The sequencer waits for the controller's acknowledge, switches the clock back, and only then raises scan enable again. The clock switch is a break-before-make handshake: two synchronizing flops sit in each clock domain, and each enable changes only while its own clock is low, so the output clock never carries a shortened pulse. A request that is not legal in the current state produces a one-cycle error pulse and is otherwise ignored.

Top module: `scan_mode_seq`

## Requirements
- R1: While reset is held and immediately after it is released, the sequencer is in functional mode: mode_o=2'b00, and test_mode_o, scan_en_o, cg_force_o, iso_en_o, clk_sel_o, cap_req_o and err_o are all 0.
- R2: In functional mode (mode_o=2'b00), test_mode_o=0, scan_en_o=0 and cg_force_o=0, iso_o equals iso_in_i, and blk_rst_no equals func_rst_ni.
- R3: A req_shift_i pulse in functional mode moves to shift mode (mode_o=2'b01) in the next cycle, with test_mode_o=1, scan_en_o=1, cg_force_o=1 and clk_sel_o=0.
- R4: Whenever test_mode_o is 1, blk_rst_no is 1 whatever func_rst_ni is, iso_en_o is 1, and iso_o is all zeros.
- R5: A req_capture_i pulse in shift mode enters capture mode (mode_o=2'b10) in the next cycle with scan_en_o=0 and test_mode_o=1. cap_req_o then stays low for at least N+1 cycles after scan_en_o falls, where N is settle_cfg_i and a value of 0 counts as 1.
- R6: While cap_req_o is high, cap_pulses_o equals burst_cfg_i+1 as sampled at the capture request. cap_req_o stays high until cap_ack_i is seen, and afterwards the sequencer returns to shift mode with scan_en_o=1 and cap_req_o=0.
- R7: clk_sel_o is 1 from the capture request until the return to shift. cap_req_o rises only after the capture clock has taken over. Every high pulse on clk_o is a full high phase of either shift_clk_i or cap_clk_i.
- R8: A req_func_i pulse in shift mode returns to functional mode in the next cycle. test_mode_o, iso_en_o and the reset gate all release in that same cycle.
- R9: An illegal request raises err_o for exactly one cycle, starting the cycle after the request, and leaves mode_o unchanged. Illegal requests are: more than one request bit at once, req_capture_i in functional mode, and any request while in capture mode. A request for the current stable mode is a silent no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_clk_i | input | 1 | Slow shift / functional clock source |
| cap_clk_i | input | 1 | Fast at-speed capture clock source |
| req_func_i | input | 1 | Request: return to functional mode |
| req_shift_i | input | 1 | Request: enter scan-shift mode |
| req_capture_i | input | 1 | Request: perform a capture |
| settle_cfg_i | input | SETTLE_W | Scan-enable settle cycles (0 treated as 1) |
| burst_cfg_i | input | BURST_W | Capture pulses minus one |
| cap_ack_i | input | 1 | Clock controller reports burst done |
| func_rst_ni | input | 1 | Functional active-low reset for the block |
| iso_in_i | input | ISO_W | Interface signals to be isolated |
| test_mode_o | output | 1 | Test mode flag |
| scan_en_o | output | 1 | Scan enable |
| cg_force_o | output | 1 | Forces the clock gate open |
| clk_sel_o | output | 1 | Requested clock source, 1 = capture clock |
| clk_o | output | 1 | Glitch-free switched clock |
| blk_rst_no | output | 1 | Gated active-low reset to the block |
| iso_en_o | output | 1 | Isolation active |
| iso_o | output | ISO_W | Isolated interface signals |
| cap_req_o | output | 1 | Capture burst request to the clock controller |
| cap_pulses_o | output | BURST_W+1 | Number of capture pulses requested |
| mode_o | output | 2 | Current mode: 00 functional, 01 shift, 10 capture |
| err_o | output | 1 | One-cycle illegal-request pulse |

## Verification
The bench targets the settle window at both extremes of the configuration, including a zero setting. A design that skipped the clamp or counted one cycle short would raise the capture request while scan enable was still spreading. It measures the width of every high pulse on the switched clock, so an enable that changes while its clock is high shows up as a sliver pulse. It also fires requests that are illegal in the current state, including one during the settle phase. A design that obeyed such a request would change mode, and one that latched the error would hold it high for more than a cycle. Finally, the bench holds the functional reset low during test, which exposes any reset gate that leaks.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    ST_FUNC   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CAPT   = 3'd3,
    ST_RET    = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    MODE_FUNC  = 2'b00,
    MODE_SHIFT = 2'b01,
    MODE_CAPT  = 2'b10
  } mode_e;

  typedef struct packed {
    logic test_mode;
    logic scan_en;
    logic clk_sel;
    logic cap_req;
  } ctrl_t;

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/scan_clk_switch.sv
module scan_clk_switch #(
  parameter int STAGES = 2
) (
  input  logic rst_ni,
  input  logic clk_a_i,   // shift clock
  input  logic clk_b_i,   // capture clock
  input  logic sel_b_i,
  output logic clk_o,
  output logic a_on_o,
  output logic b_on_o
);

  localparam int NDOM = 2;

  logic [NDOM-1:0] clks;
  logic [NDOM-1:0] want;
  logic [NDOM-1:0] want_s;
  logic [NDOM-1:0] en;

  assign clks = {clk_b_i, clk_a_i};
  // break-before-make: a domain may turn on only once the other is off
  assign want[0] = ~sel_b_i & ~en[1];
  assign want[1] =  sel_b_i & ~en[0];

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    logic en_q;

    scan_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk_i (clks[g]),
      .rst_ni(rst_ni),
      .d_i   (want[g]),
      .q_o   (want_s[g])
    );

    // enable changes only while its clock is low
    always_ff @(negedge clks[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= want_s[g];
    end

    assign en[g] = en_q;
  end

  assign clk_o  = (clk_a_i & en[0]) | (clk_b_i & en[1]);
  assign a_on_o = en[0];
  assign b_on_o = en[1];

  always @(posedge clk_a_i) begin
    if (rst_ni) begin
      p_en_exclusive_r7: assert (!(en[0] && en[1]))
        else $error("both clock enables active");
    end
  end

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int SETTLE_W = 4,
  parameter int BURST_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_func_i,
  input  logic                req_shift_i,
  input  logic                req_capture_i,
  input  logic [SETTLE_W-1:0] settle_cfg_i,
  input  logic [BURST_W-1:0]  burst_cfg_i,
  input  logic                cap_ack_i,
  input  logic                shf_on_i,
  input  logic                cap_on_i,
  output ctrl_t               ctrl_o,
  output logic [1:0]          mode_o,
  output logic [BURST_W:0]    cap_pulses_o,
  output logic                err_o
);

  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  seq_st_e             st_q, st_d;
  logic [SETTLE_W-1:0] cnt_q;
  logic [BURST_W:0]    pulses_q;
  logic                err_q;
  logic                illegal;
  logic                any_req;
  logic                multi_req;
  logic                shf_ready;
  logic                cap_ready;

  assign any_req   = req_func_i | req_shift_i | req_capture_i;
  assign multi_req = (req_func_i & req_shift_i) | (req_func_i & req_capture_i)
                   | (req_shift_i & req_capture_i);
  assign shf_ready = shf_on_i & ~cap_on_i;
  assign cap_ready = cap_on_i & ~shf_on_i;

  always_comb begin
    st_d    = st_q;
    illegal = 1'b0;
    unique case (st_q)
      ST_FUNC: begin
        if (multi_req || req_capture_i) illegal = 1'b1;
        else if (req_shift_i)           st_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (multi_req)          illegal = 1'b1;
        else if (req_capture_i) st_d = ST_SETTLE;
        else if (req_func_i)    st_d = ST_FUNC;
      end
      ST_SETTLE: begin
        if (any_req)                           illegal = 1'b1;
        else if (cnt_q == '0 && cap_ready)     st_d = ST_CAPT;
      end
      ST_CAPT: begin
        illegal = any_req;
        if (cap_ack_i) st_d = ST_RET;   // ack is never lost to a stray request
      end
      ST_RET: begin
        if (any_req)        illegal = 1'b1;
        else if (shf_ready) st_d = ST_SHIFT;
      end
      default: st_d = ST_FUNC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_FUNC;
      cnt_q    <= '0;
      pulses_q <= '0;
      err_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= illegal;
      if (st_q == ST_SHIFT && st_d == ST_SETTLE) begin
        cnt_q    <= (settle_cfg_i == '0) ? CNT_ONE : settle_cfg_i;
        pulses_q <= {1'b0, burst_cfg_i} + 1'b1;
      end else if (st_q == ST_SETTLE && cnt_q != '0 && !any_req) begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  always_comb begin
    ctrl_o = '0;
    mode_o = MODE_CAPT;
    unique case (st_q)
      ST_FUNC:   mode_o = MODE_FUNC;
      ST_SHIFT: begin
        mode_o         = MODE_SHIFT;
        ctrl_o.test_mode = 1'b1;
        ctrl_o.scan_en   = 1'b1;
      end
      ST_SETTLE: begin
        ctrl_o.test_mode = 1'b1;
        ctrl_o.clk_sel   = 1'b1;
      end
      ST_CAPT: begin
        ctrl_o.test_mode = 1'b1;
        ctrl_o.clk_sel   = 1'b1;
        ctrl_o.cap_req   = 1'b1;
      end
      ST_RET:    ctrl_o.test_mode = 1'b1;
      default:   mode_o = MODE_FUNC;
    endcase
  end

  assign cap_pulses_o = pulses_q;
  assign err_o        = err_q;

  p_err_keeps_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> mode_o == $past(mode_o));

  p_capreq_until_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.cap_req && !cap_ack_i) |=> ctrl_o.cap_req);

  p_pulses_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.cap_req && $past(ctrl_o.cap_req)) |-> $stable(cap_pulses_o));

  p_func_from_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o.test_mode) |-> $past(ctrl_o.scan_en));

endmodule

// File: rtl/scan_mode_seq.sv
module scan_mode_seq
  import scan_seq_pkg::*;
#(
  parameter int SETTLE_W    = 4,
  parameter int BURST_W     = 2,
  parameter int ISO_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_clk_i,
  input  logic                cap_clk_i,
  input  logic                req_func_i,
  input  logic                req_shift_i,
  input  logic                req_capture_i,
  input  logic [SETTLE_W-1:0] settle_cfg_i,
  input  logic [BURST_W-1:0]  burst_cfg_i,
  input  logic                cap_ack_i,
  input  logic                func_rst_ni,
  input  logic [ISO_W-1:0]    iso_in_i,
  output logic                test_mode_o,
  output logic                scan_en_o,
  output logic                cg_force_o,
  output logic                clk_sel_o,
  output logic                clk_o,
  output logic                blk_rst_no,
  output logic                iso_en_o,
  output logic [ISO_W-1:0]    iso_o,
  output logic                cap_req_o,
  output logic [BURST_W:0]    cap_pulses_o,
  output logic [1:0]          mode_o,
  output logic                err_o
);

  localparam int CHK_W = SETTLE_W + 1;

  ctrl_t      ctrl;
  logic       a_on;
  logic       b_on;
  logic [1:0] on_s;

  scan_clk_switch #(.STAGES(SYNC_STAGES)) u_clk_switch (
    .rst_ni (rst_ni),
    .clk_a_i(shift_clk_i),
    .clk_b_i(cap_clk_i),
    .sel_b_i(ctrl.clk_sel),
    .clk_o  (clk_o),
    .a_on_o (a_on),
    .b_on_o (b_on)
  );

  scan_sync #(.W(2), .STAGES(SYNC_STAGES)) u_on_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({b_on, a_on}),
    .q_o   (on_s)
  );

  scan_seq_fsm #(.SETTLE_W(SETTLE_W), .BURST_W(BURST_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_func_i   (req_func_i),
    .req_shift_i  (req_shift_i),
    .req_capture_i(req_capture_i),
    .settle_cfg_i (settle_cfg_i),
    .burst_cfg_i  (burst_cfg_i),
    .cap_ack_i    (cap_ack_i),
    .shf_on_i     (on_s[0]),
    .cap_on_i     (on_s[1]),
    .ctrl_o       (ctrl),
    .mode_o       (mode_o),
    .cap_pulses_o (cap_pulses_o),
    .err_o        (err_o)
  );

  assign test_mode_o = ctrl.test_mode;
  assign scan_en_o   = ctrl.scan_en;
  assign clk_sel_o   = ctrl.clk_sel;
  assign cap_req_o   = ctrl.cap_req;
  assign cg_force_o  = ctrl.test_mode;
  assign iso_en_o    = ctrl.test_mode;
  assign blk_rst_no  = func_rst_ni | ctrl.test_mode;
  assign iso_o       = ctrl.test_mode ? '0 : iso_in_i;

  // settle-window checker: cycles since scan enable last seen high
  logic [CHK_W-1:0]    se_low_cnt;
  logic [SETTLE_W-1:0] settle_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_low_cnt <= '0;
      settle_l   <= '0;
    end else if (scan_en_o) begin
      se_low_cnt <= '0;
      settle_l   <= (settle_cfg_i == '0) ? SETTLE_W'(1) : settle_cfg_i;
    end else if (se_low_cnt != '1) begin
      se_low_cnt <= se_low_cnt + 1'b1;
    end
  end

  p_settle_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_req_o) |-> se_low_cnt > {1'b0, settle_l});

  p_capreq_fast_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_req_o |-> (on_s[1] && !on_s[0] && clk_sel_o));

  p_shift_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scan_en_o) && $past(test_mode_o)) |-> (on_s[0] && !on_s[1]));

endmodule

// File: tb/scan_mode_seq_tb_top.sv
`timescale 1ns/1ps
module scan_mode_seq_tb_top;

  localparam int SETTLE_W = 4;
  localparam int BURST_W  = 2;
  localparam int ISO_W    = 8;
  localparam logic [1:0] M_FUNC = 2'b00, M_SHIFT = 2'b01, M_CAPT = 2'b10;

  logic clk_i = 1'b0, shift_clk_i = 1'b0, cap_clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_func_i = 0, req_shift_i = 0, req_capture_i = 0, cap_ack_i = 0;
  logic [SETTLE_W-1:0] settle_cfg_i = '0;
  logic [BURST_W-1:0]  burst_cfg_i = '0;
  logic func_rst_ni = 1'b1;
  logic [ISO_W-1:0] iso_in_i = '0;
  logic test_mode_o, scan_en_o, cg_force_o, clk_sel_o, clk_o, blk_rst_no, iso_en_o;
  logic [ISO_W-1:0] iso_o;
  logic cap_req_o, err_o;
  logic [BURST_W:0] cap_pulses_o;
  logic [1:0] mode_o;

  always #10 clk_i = ~clk_i;        // 50 MHz
  always #20 shift_clk_i = ~shift_clk_i;
  always #3  cap_clk_i = ~cap_clk_i;

  scan_mode_seq #(.SETTLE_W(SETTLE_W), .BURST_W(BURST_W), .ISO_W(ISO_W)) dut_i (
    .clk_i, .rst_ni, .shift_clk_i, .cap_clk_i, .req_func_i, .req_shift_i,
    .req_capture_i, .settle_cfg_i, .burst_cfg_i, .cap_ack_i, .func_rst_ni,
    .iso_in_i, .test_mode_o, .scan_en_o, .cg_force_o, .clk_sel_o, .clk_o,
    .blk_rst_no, .iso_en_o, .iso_o, .cap_req_o, .cap_pulses_o, .mode_o, .err_o
  );

  int errs = 0, checks = 0, glitch_bad = 0, fast_pulses = 0, slow_pulses = 0;
  bit done = 0;
  bit seen_rise = 0;
  realtime t_rise = 0;

  // pulse-width monitor for R7
  always @(posedge clk_o) begin t_rise = $realtime; seen_rise = 1; end
  always @(negedge clk_o) begin
    if (rst_ni && seen_rise) begin
      realtime w;
      w = $realtime - t_rise;
      if (w > 19.5 && w < 20.5)    slow_pulses++;
      else if (w > 2.5 && w < 3.5) fast_pulses++;
      else                         glitch_bad++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  function automatic logic [1:0] exp_mode(logic [1:0] m, bit f, bit s, bit c);
    int n = int'(f) + int'(s) + int'(c);
    if (n > 1) return m;
    if (m == M_FUNC)  return s ? M_SHIFT : M_FUNC;
    if (m == M_SHIFT) return c ? M_CAPT : (f ? M_FUNC : M_SHIFT);
    return m;
  endfunction

  function automatic bit exp_err(logic [1:0] m, bit f, bit s, bit c);
    int n = int'(f) + int'(s) + int'(c);
    if (n > 1) return 1;
    if (m == M_FUNC)  return c;
    if (m == M_SHIFT) return 0;
    return n != 0;
  endfunction

  task automatic check_static(logic [1:0] m, string tag);
    if (m == M_FUNC) begin
      chk(!test_mode_o && !scan_en_o && !cg_force_o && !iso_en_o, {"R2 ", tag},
          {test_mode_o, scan_en_o, cg_force_o, iso_en_o}, 0);
      chk(iso_o == iso_in_i, {"R2 iso ", tag}, iso_o, iso_in_i);
      chk(blk_rst_no == func_rst_ni, {"R2 rst ", tag}, blk_rst_no, func_rst_ni);
    end else begin
      if (m == M_SHIFT)
        chk(test_mode_o && scan_en_o && cg_force_o && !clk_sel_o, {"R3 ", tag},
            {test_mode_o, scan_en_o, cg_force_o, clk_sel_o}, 4'b1110);
      chk(blk_rst_no && iso_en_o && iso_o == '0, {"R4 ", tag},
          {blk_rst_no, iso_en_o, iso_o}, {2'b11, {ISO_W{1'b0}}});
    end
  endtask

  task automatic run_capture(int settle, int burst, bit inject);
    int eff = (settle == 0) ? 1 : settle;
    int k = 0;
    settle_cfg_i = SETTLE_W'(settle);
    burst_cfg_i  = BURST_W'(burst);
    func_rst_ni  = 1'b0;            // must not reach the block (R4)
    req_capture_i = 1;
    tick();
    req_capture_i = 0;
    chk(mode_o == M_CAPT && !scan_en_o && test_mode_o, "R5 enter capture", mode_o, M_CAPT);
    chk(clk_sel_o == 1, "R7 sel high", clk_sel_o, 1);
    check_static(M_CAPT, "capture");
    while (k < 300) begin
      if (inject && k == 1) begin
        req_shift_i = 1;
        tick(); k++;
        req_shift_i = 0;
        chk(err_o == 1 && mode_o == M_CAPT, "R9 request in capture", {err_o, mode_o}, {1'b1, M_CAPT});
        if (cap_req_o) break;
        tick(); k++;
        chk(err_o == 0, "R9 err one cycle", err_o, 0);
        if (cap_req_o) break;
      end else begin
        tick(); k++;
        if (cap_req_o) break;
      end
    end
    chk(k >= eff + 1, "R5 settle window", k, eff + 1);
    chk(cap_pulses_o == burst + 1, "R6 pulses", cap_pulses_o, burst + 1);
    chk(clk_sel_o && !scan_en_o, "R7 fast clock selected", clk_sel_o, 1);
    repeat (1 + $urandom % 4) tick();
    chk(cap_req_o == 1, "R6 hold until ack", cap_req_o, 1);
    cap_ack_i = 1;
    tick();
    cap_ack_i = 0;
    k = 0;
    while (mode_o != M_SHIFT && k < 300) begin tick(); k++; end
    chk(mode_o == M_SHIFT && scan_en_o && !cap_req_o && !clk_sel_o, "R6 back to shift",
        {mode_o, scan_en_o, cap_req_o, clk_sel_o}, {M_SHIFT, 3'b100});
    func_rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [1:0] m;
    void'($urandom(32'h1234ABCD));
    #5;
    chk(mode_o == M_FUNC && !test_mode_o && !scan_en_o && !err_o, "R1 in reset",
        {mode_o, test_mode_o, scan_en_o, err_o}, 0);
    repeat (3) tick();
    rst_ni = 1;
    tick();
    chk(mode_o == M_FUNC && !test_mode_o && !scan_en_o && !cg_force_o && !iso_en_o
        && !clk_sel_o && !cap_req_o && !err_o, "R1 after reset", mode_o, M_FUNC);
    repeat (20) tick();

    // functional pass-through
    iso_in_i = 8'hA5; func_rst_ni = 0; #1;
    check_static(M_FUNC, "pass A5");
    // capture request from functional is illegal
    req_capture_i = 1; tick(); req_capture_i = 0;
    chk(err_o == 1 && mode_o == M_FUNC, "R9 capture from func", {err_o, mode_o}, 4);
    tick();
    chk(err_o == 0, "R9 err one cycle", err_o, 0);
    func_rst_ni = 1;
    // enter shift
    req_shift_i = 1; tick(); req_shift_i = 0;
    chk(mode_o == M_SHIFT && !err_o, "R3 shift entry", mode_o, M_SHIFT);
    func_rst_ni = 0; #1;
    check_static(M_SHIFT, "shift");
    func_rst_ni = 1;
    repeat (4) tick();
    run_capture(0, 0, 0);
    run_capture(15, 3, 1);
    run_capture(1, 2, 0);
    // return to functional (R8)
    req_func_i = 1; tick(); req_func_i = 0;
    chk(mode_o == M_FUNC && !test_mode_o && !iso_en_o && !cg_force_o, "R8 release together",
        {mode_o, test_mode_o, iso_en_o}, 0);
    check_static(M_FUNC, "R8 after return");

    // constrained random requests
    m = M_FUNC;
    for (int it = 0; it < 80; it++) begin
      logic [2:0] r;
      logic [1:0] em;
      bit ee;
      r = 3'($urandom % 8);
      if (r == 3'b111 && ($urandom % 2)) r = 3'b000;
      iso_in_i = 8'($urandom);
      func_rst_ni = 1'($urandom);
      em = exp_mode(m, r[0], r[1], r[2]);
      ee = exp_err(m, r[0], r[1], r[2]);
      if (m == M_SHIFT && r == 3'b100) begin
        run_capture(int'($urandom % 16), int'($urandom % 4), (it % 3) == 0);
        continue;
      end
      req_func_i = r[0]; req_shift_i = r[1]; req_capture_i = r[2];
      tick();
      req_func_i = 0; req_shift_i = 0; req_capture_i = 0;
      chk(err_o == ee, "R9 random err", err_o, ee);
      chk(mode_o == em, (m == M_SHIFT && em == M_FUNC) ? "R8 random mode" : "R3 random mode",
          mode_o, em);
      check_static(em, "random");
      m = em;
      tick();
      chk(err_o == 0, "R9 err cleared", err_o, 0);
      check_static(m, "random hold");
    end

    chk(glitch_bad == 0, "R7 no short clock pulse", glitch_bad, 0);
    chk(fast_pulses > 0 && slow_pulses > 0, "R7 both clocks delivered", fast_pulses, 1);
    finish_run();
  end

endmodule